// File: doc/BRIEF.md
# Speculative Carry Select Adder

This block adds two unsigned operands approximately in exchange for a short carry path. The operand width is cut into slices of a fixed size. Every slice above the lowest one holds two small adders: one assumes no incoming carry and one assumes an incoming carry. A slice's incoming carry is guessed from the slice just below it alone: the guess is the carry-out that this lower slice gives when it adds its own bits with no carry in. So no carry crosses more than one slice boundary, and the longest path is one slice adder plus one multiplexer.

The lowest slice adds with a carry-in of zero and has no second adder. When the width is not a multiple of the slice size, the top slice is narrower and holds the bits that are left over. The carry-out of the whole block comes from the adder that was selected in the top slice. Each slice adder uses a parallel-prefix lookahead carry network. The sum and the carry-out are registered, and a synchronous active-high reset clears them.

The block suits error-tolerant datapaths. A missed carry can only make the result smaller, and it only happens when a whole slice propagates a carry that it did not generate itself.

Top module: `scsa_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_o` and `carry_o` become zero after that edge, whatever the operands are.
- R2: The outputs show the result for the operands that were present at the previous rising edge. A change of the operands between edges leaves the outputs as they were.
- R3: The lowest slice, bits [BLK-1:0], gives the exact sum of the operand bits in that slice with no carry-in.
- R4: Slice i > 0 gives (a_i + b_i + g_i) mod 2^w_i. Here g_i is the carry-out of a_{i-1} + b_{i-1}, the previous slice's own bits added with carry-in zero, and w_i is the width of slice i.
- R5: The result {carry_o, sum_o} is never larger than the exact sum. A carry that must cross two or more slice boundaries is dropped. With WIDTH=16 and BLK=4, 0x00FF + 0x0001 gives 0x0000.
- R6: `carry_o` is the carry-out of the adder selected in the top slice.
- R7: When WIDTH is not a multiple of BLK, the top slice holds WIDTH mod BLK bits and is still fed a speculated carry. With WIDTH=16 and BLK=3, 0x4000 + 0x4000 gives sum 0x8000 with carry_o 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | WIDTH | First unsigned operand |
| opnd_b | input | WIDTH | Second unsigned operand |
| sum_o | output | WIDTH | Registered approximate sum |
| carry_o | output | 1 | Registered carry-out of the top slice |

## Verification
A wrong select inside a slice shows up at the port one clock later. It appears as an error of exactly one unit at that slice's least significant bit, and the operand patterns that expose it are those where the lower slice generates a carry on its own. A prefix network that computes a wrong lookahead carry corrupts bits inside one slice, so the bench uses operands with long propagate runs within a slice. The narrow top slice and the carry-out are exercised with a second instance whose slice size does not divide the width.

// File: rtl/scsa_pkg.sv
package scsa_pkg;
  // Number of slices for a given width and slice size
  function automatic int num_blk(int wd, int bk);
    return (wd + bk - 1) / bk;
  endfunction

  // Width of slice idx: the top slice takes what is left over
  function automatic int blk_w(int wd, int bk, int idx);
    return (idx == num_blk(wd, bk) - 1) ? (wd - idx * bk) : bk;
  endfunction
endpackage

// File: rtl/scsa_cla.sv
// Parallel-prefix (Kogge-Stone style) adder with a fixed carry-in
module scsa_cla #(
  parameter int  W   = 4,
  parameter bit  CIN = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int LV = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] gl [LV+1];
  logic [W-1:0] pl [LV+1];
  logic [W:0]   cy;

  always_comb begin
    gl[0] = a & b;
    pl[0] = a ^ b;
    for (int l = 0; l < LV; l++) begin
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << l)) begin
          gl[l+1][i] = gl[l][i] | (pl[l][i] & gl[l][i-(1<<l)]);
          pl[l+1][i] = pl[l][i] & pl[l][i-(1<<l)];
        end else begin
          gl[l+1][i] = gl[l][i];
          pl[l+1][i] = pl[l][i];
        end
      end
    end
    cy[0] = CIN;
    for (int i = 0; i < W; i++) begin
      cy[i+1] = gl[LV][i] | (pl[LV][i] & CIN);
    end
  end

  assign s  = pl[0] ^ cy[W-1:0];
  assign co = cy[W];
endmodule

// File: rtl/scsa_block.sv
// One upper slice: two prefix adders and a select multiplexer
module scsa_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co_sel,
  output logic         co_zero
);
  logic [W-1:0] s0, s1;
  logic         c1;

  scsa_cla #(.W(W), .CIN(1'b0)) u_add0 (.a(a), .b(b), .s(s0), .co(co_zero));
  scsa_cla #(.W(W), .CIN(1'b1)) u_add1 (.a(a), .b(b), .s(s1), .co(c1));

  assign s      = sel ? s1 : s0;
  assign co_sel = sel ? c1 : co_zero;
endmodule

// File: rtl/scsa_adder.sv
module scsa_adder #(
  parameter int WIDTH = 16,
  parameter int BLK   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int NBLK = scsa_pkg::num_blk(WIDTH, BLK);

  logic [NBLK-1:0]  cz;   // carry-out of each slice's carry-in-0 adder
  logic [NBLK-1:0]  cs;   // carry-out of each slice's selected adder
  logic [WIDTH-1:0] sum_c;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    localparam int LO = i * BLK;
    localparam int W  = scsa_pkg::blk_w(WIDTH, BLK, i);
    if (i == 0) begin : g_low
      scsa_cla #(.W(W), .CIN(1'b0)) u_add (
        .a(opnd_a[LO +: W]), .b(opnd_b[LO +: W]),
        .s(sum_c[LO +: W]), .co(cz[i]));
      assign cs[i] = cz[i];
    end else begin : g_up
      scsa_block #(.W(W)) u_blk (
        .a(opnd_a[LO +: W]), .b(opnd_b[LO +: W]), .sel(cz[i-1]),
        .s(sum_c[LO +: W]), .co_sel(cs[i]), .co_zero(cz[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      sum_o   <= sum_c;
      carry_o <= cs[NBLK-1];
    end
  end
endmodule

// File: rtl/scsa_chk.sv
module scsa_chk #(
  parameter int WIDTH = 16,
  parameter int BLK   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o
);
  logic [WIDTH:0]   exact;
  logic [BLK-1:0]   lo_exp;
  logic [WIDTH-1:0] m_sum;
  logic             m_cout;

  assign exact = {1'b0, opnd_a} + {1'b0, opnd_b};

  // Bit-serial speculation model, independent of the prefix networks
  always_comb begin
    logic c, z;
    c = 1'b0;
    z = 1'b0;
    lo_exp = '0;
    for (int j = 0; j < WIDTH; j++) begin
      if (j % BLK == 0) begin
        c = z;
        z = 1'b0;
      end
      m_sum[j] = opnd_a[j] ^ opnd_b[j] ^ c;
      c = (opnd_a[j] & opnd_b[j]) | (c & (opnd_a[j] ^ opnd_b[j]));
      z = (opnd_a[j] & opnd_b[j]) | (z & (opnd_a[j] ^ opnd_b[j]));
      if (j < BLK) lo_exp[j] = m_sum[j];
    end
    m_cout = c;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sum_o == '0) && !carry_o);

  p_low_exact_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sum_o[BLK-1:0] == $past(lo_exp));

  p_spec_sum_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sum_o == $past(m_sum));

  p_no_overestimate_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> {carry_o, sum_o} <= $past(exact));

  p_carry_out_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> carry_o == $past(m_cout));
endmodule

bind scsa_adder scsa_chk #(.WIDTH(WIDTH), .BLK(BLK)) u_chk (
  .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .sum_o(sum_o), .carry_o(carry_o));

// File: tb/scsa_adder_tb.sv
module scsa_adder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0, b = '0;
  logic [15:0] sum4, sum3;
  logic        co4, co3;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  scsa_adder #(.WIDTH(16), .BLK(4)) u_dut (
    .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .sum_o(sum4), .carry_o(co4));
  scsa_adder #(.WIDTH(16), .BLK(3)) u_dut3 (
    .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .sum_o(sum3), .carry_o(co3));

  // {a, b, expected carry, expected sum} for slice size 4
  localparam logic [48:0] VEC [8] = '{
    {16'h1234, 16'h4321, 1'b0, 16'h5555},  // R4 no carries
    {16'h00FF, 16'h0001, 1'b0, 16'h0000},  // R5 two-boundary carry lost
    {16'hFFFF, 16'h0001, 1'b0, 16'hFF00},  // R5 R6 long propagate
    {16'h8000, 16'h8000, 1'b1, 16'h0000},  // R6 top carry
    {16'h0088, 16'h0088, 1'b0, 16'h0110},  // R4 speculated carry used
    {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFE},  // R6 all ones
    {16'h0F0F, 16'h00F1, 1'b0, 16'h0F00},  // R3 R4 mixed
    {16'h7FFF, 16'h0001, 1'b0, 16'h7F00}   // R5
  };

  task automatic chk(string req, logic [16:0] got, logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic [15:0] va, logic [15:0] vb);
    @(negedge clk);
    a = va;
    b = vb;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    a = 16'hFFFF; b = 16'hFFFF;
    @(negedge clk);
    chk("R1 reset slice4", {co4, sum4}, 17'h0);
    chk("R1 reset slice3", {co3, sum3}, 17'h0);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][48:33], VEC[i][32:17]);
      chk("R3 R4 R5 R6 vector", {co4, sum4}, VEC[i][16:0]);
      chk("R3 low slice exact", {13'h0, sum4[3:0]},
          {13'h0, VEC[i][36:33] + VEC[i][20:17]});
    end

    // R2: mid-cycle operand change leaves the outputs untouched
    apply(16'h1111, 16'h2222);
    a = 16'h4444; b = 16'h4444;
    #2;
    chk("R2 hold between edges", {co4, sum4}, 17'h03333);
    @(negedge clk);
    chk("R2 one-cycle latency", {co4, sum4}, 17'h08888);

    // R7: slice size 3, top slice is one bit wide
    apply(16'h4000, 16'h4000);
    chk("R7 narrow top gets speculated carry", {co3, sum3}, 17'h08000);
    apply(16'h8000, 16'h8000);
    chk("R7 R6 narrow top carry-out", {co3, sum3}, 17'h10000);
    apply(16'hFFFF, 16'h0001);
    chk("R7 R5 slice3 long propagate", {co3, sum3}, 17'h0FFC0);

    // R1: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-run", {co4, sum4}, 17'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule